// File: doc/BRIEF.md
# Multi-Channel Interprocessor Mailbox Controller

The controller lets up to four processors ("users") exchange 32-bit messages through eight independent one-way mailboxes. Each mailbox is a four-entry FIFO. A sender posts a word by writing that mailbox's message register, and the receiver takes the oldest word by reading the same register. Everything is reached through one memory-mapped port with a word address, write and read strobes, write data and read data.

Each user has its own interrupt status register and its own enable register. These cover two events for every mailbox. The first is "message waiting", meant for the receiver. The second is "space freed after full", meant for the sender. A user's interrupt line is the OR of the status bits that user has enabled, so one set of FIFOs serves four independent interrupt lines.

Word address map (defaults): 0..7 mailbox message registers; 8..15 mailbox status registers; 16..19 interrupt status of users 0..3; 20..23 interrupt enable of users 0..3. Reads of other addresses return zero. Read data is combinational and is zero while the read strobe is low. Read and write strobes are never asserted in the same cycle.

Top module: `mbx_hub`

## Requirements
- R1: After reset every mailbox is empty, every status, overflow and enable bit is zero, and all four interrupt lines are low.
- R2: A write to message register m (address m) appends the data to mailbox m. A read of address m returns the oldest queued word and removes it, so words come out in the order they were written.
- R3: A read of an empty mailbox's message register returns zero and leaves its count at zero.
- R4: A write to a full mailbox (four words queued) is discarded and sets that mailbox's sticky overflow bit, which is bit 8 of status register 8+m. Writing a 1 to bit 8 of that register clears the overflow bit.
- R5: Status register 8+m reads the mailbox's word count (0 to 4) in bits [2:0] and a full flag in bit 4. Every other bit except bit 8 reads zero.
- R6: In each user's interrupt status register, bit m (0..7) is the message-waiting bit of mailbox m. It is 1 whenever mailbox m holds at least one word after the current cycle. Writing 1 to it drops it for exactly that one cycle, and it reads 1 again afterwards if words remain.
- R7: Bit 8+m of each user's interrupt status register is set when a word is removed from mailbox m while it was full. It stays set until that user writes 1 to that bit.
- R8: Interrupt line u is high exactly when the bitwise AND of user u's interrupt status and interrupt enable registers is non-zero. The line follows register state with no extra delay.
- R9: The interrupt enable register of user u (address 20+u, bits [15:0] with the same layout as the status register) reads back the value written. Traffic on one mailbox never changes the count, data or status bits of another mailbox.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (5) | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a read of a message register pops it |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| irq | output | NUM_USERS (4) | One interrupt line per user |

## Verification
Directed phases check specific behaviours one at a time. They fill a mailbox through the overflow limit and drain it past empty, which separates the drop and zero-read cases from plain FIFO order. They clear bits while words remain, which tells a level-following message-waiting bit from a sticky one. They program enable masks that differ per user, so that an interrupt taken from the wrong user or the wrong event class shows up on the lines. A long pseudo-random phase then interleaves posts, fetches, clears and enable writes across all eight mailboxes. This exposes crosstalk between mailboxes and pointer-wrap errors that the short directed sequences never reach.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // register classes inside the word address space
  typedef enum logic [2:0] {
    RK_MSG,
    RK_MBST,
    RK_IRQST,
    RK_IRQEN,
    RK_NONE
  } reg_kind_e;

  // bit positions inside a mailbox status word
  localparam int MBST_FULL_BIT = 4;
  localparam int MBST_OVF_BIT  = 8;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter  int DW    = 32,
  parameter  int DEPTH = 4,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          ovf_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          nonempty,
  output logic          nonempty_nxt,
  output logic          nf_evt,
  output logic          ovf
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          do_push, do_pop;

  assign full     = (cnt_q == CW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign do_push  = push & ~full;
  assign do_pop   = pop & nonempty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    ovf_d = (push & full) | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // storage: clock-enabled, no reset needed
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= wdata;
  end

  assign head         = nonempty ? mem_q[rp_q] : '0;
  assign count        = cnt_q;
  assign nonempty_nxt = (cnt_d != '0);
  assign nf_evt       = full & do_pop;
  assign ovf          = ovf_q;

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q)));
  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ovf_q);
  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !nonempty && !push) |=> (cnt_q == '0));
  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/mbx_user.sv
module mbx_user #(
  parameter  int NMB = 8,
  localparam int SW  = 2 * NMB
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NMB-1:0] nonempty,
  input  logic [NMB-1:0] nonempty_nxt,
  input  logic [NMB-1:0] nf_evt,
  input  logic           st_wr,
  input  logic           en_wr,
  input  logic [SW-1:0]  wdata,
  output logic [SW-1:0]  st,
  output logic [SW-1:0]  en,
  output logic           irq
);
  logic [NMB-1:0] new_q, new_d, nf_q, nf_d, clr_new, clr_nf;
  logic [SW-1:0]  en_q, en_d;

  always_comb begin
    clr_new = st_wr ? wdata[NMB-1:0]  : '0;
    clr_nf  = st_wr ? wdata[SW-1:NMB] : '0;
    new_d   = nonempty_nxt & ~clr_new;
    nf_d    = nf_evt | (nf_q & ~clr_nf);
    en_d    = en_wr ? wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_q <= '0;
      nf_q  <= '0;
      en_q  <= '0;
    end else begin
      new_q <= new_d;
      nf_q  <= nf_d;
      en_q  <= en_d;
    end
  end

  assign st  = {nf_q, new_q};
  assign en  = en_q;
  assign irq = |(st & en_q);

  // R7
  nf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(nf_q) & ~$past(clr_nf)) & ~nf_q) == '0));
  // R6
  new_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((nonempty & ~$past(clr_new)) & ~new_q) == '0));
  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

// File: rtl/mbx_hub.sv
module mbx_hub #(
  parameter  int NUM_MBOX  = 8,
  parameter  int DEPTH     = 4,
  parameter  int DW        = 32,
  parameter  int NUM_USERS = 4,
  parameter  int ADDR_W    = 5,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int SW        = 2 * NUM_MBOX,
  localparam int BASE_MBST = NUM_MBOX,
  localparam int BASE_IST  = 2 * NUM_MBOX,
  localparam int BASE_IEN  = 2 * NUM_MBOX + NUM_USERS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DW-1:0]        bus_wdata,
  input  logic                 bus_rd,
  output logic [DW-1:0]        bus_rdata,
  output logic [NUM_USERS-1:0] irq
);
  import mbx_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic rs1_q, rs2_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  logic [DW-1:0]       head_a  [NUM_MBOX];
  logic [CW-1:0]       count_a [NUM_MBOX];
  logic [NUM_MBOX-1:0] full_v, ne_v, ne_nxt_v, nf_evt_v, ovf_v;
  logic [NUM_MBOX-1:0] push_v, pop_v, oclr_v;
  logic [SW-1:0]       st_a [NUM_USERS];
  logic [SW-1:0]       en_a [NUM_USERS];

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
    assign push_v[m] = bus_wr & (bus_addr == ADDR_W'(m));
    assign pop_v[m]  = bus_rd & (bus_addr == ADDR_W'(m));
    assign oclr_v[m] = bus_wr & (bus_addr == ADDR_W'(BASE_MBST + m))
                       & bus_wdata[MBST_OVF_BIT];
    mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk         (clk),
      .rst_n       (srst_n),
      .push        (push_v[m]),
      .pop         (pop_v[m]),
      .ovf_clr     (oclr_v[m]),
      .wdata       (bus_wdata),
      .head        (head_a[m]),
      .count       (count_a[m]),
      .full        (full_v[m]),
      .nonempty    (ne_v[m]),
      .nonempty_nxt(ne_nxt_v[m]),
      .nf_evt      (nf_evt_v[m]),
      .ovf         (ovf_v[m])
    );
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    logic st_wr, en_wr;
    assign st_wr = bus_wr & (bus_addr == ADDR_W'(BASE_IST + u));
    assign en_wr = bus_wr & (bus_addr == ADDR_W'(BASE_IEN + u));
    mbx_user #(.NMB(NUM_MBOX)) u_user (
      .clk         (clk),
      .rst_n       (srst_n),
      .nonempty    (ne_v),
      .nonempty_nxt(ne_nxt_v),
      .nf_evt      (nf_evt_v),
      .st_wr       (st_wr),
      .en_wr       (en_wr),
      .wdata       (bus_wdata[SW-1:0]),
      .st          (st_a[u]),
      .en          (en_a[u]),
      .irq         (irq[u])
    );
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      for (int m = 0; m < NUM_MBOX; m++) begin
        if (bus_addr == ADDR_W'(m)) bus_rdata = head_a[m];
        if (bus_addr == ADDR_W'(BASE_MBST + m)) begin
          bus_rdata[CW-1:0]          = count_a[m];
          bus_rdata[MBST_FULL_BIT]   = full_v[m];
          bus_rdata[MBST_OVF_BIT]    = ovf_v[m];
        end
      end
      for (int u = 0; u < NUM_USERS; u++) begin
        if (bus_addr == ADDR_W'(BASE_IST + u)) bus_rdata[SW-1:0] = st_a[u];
        if (bus_addr == ADDR_W'(BASE_IEN + u)) bus_rdata[SW-1:0] = en_a[u];
      end
    end
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) !srst_n |-> (irq == '0));
  // R3
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && (bus_addr < ADDR_W'(NUM_MBOX)) && ((ne_v >> bus_addr) & 1) == 0)
    |-> (bus_rdata == '0));
  // R9
  quiet_rdata_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/mbx_hub_tb.sv
`timescale 1ns/1ps
module mbx_hub_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // reference model
  logic [31:0] q [8][$];
  bit          m_ovf [8];
  logic [7:0]  m_new [4];
  logic [7:0]  m_nf  [4];
  logic [15:0] m_en  [4];

  always #2 clk = ~clk;

  mbx_hub u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_rd(input int a);
    logic [31:0] v;
    v = '0;
    if (a < 8) begin
      if (q[a].size() > 0) v = q[a][0];
    end else if (a < 16) begin
      v[2:0] = 3'(q[a-8].size());
      v[4]   = (q[a-8].size() == 4);
      v[8]   = m_ovf[a-8];
    end else if (a < 20) begin
      v[15:0] = {m_nf[a-16], m_new[a-16]};
    end else if (a < 24) begin
      v[15:0] = m_en[a-20];
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_irq();
    logic [3:0] e;
    for (int u = 0; u < 4; u++) e[u] = |({m_nf[u], m_new[u]} & m_en[u]);
    check("R8 irq", {28'b0, irq}, {28'b0, e});
  endtask

  task automatic step(input string tag, input bit rd, input bit wr,
                      input int a, input logic [31:0] wd);
    logic [7:0] ne;
    logic [7:0] nfs;
    logic [15:0] clr;
    @(negedge clk);
    check_irq();
    bus_rd = rd; bus_wr = wr; bus_addr = 5'(a); bus_wdata = wd;
    #1;
    check(tag, bus_rdata, rd ? exp_rd(a) : 32'h0);
    @(posedge clk);
    nfs = '0;
    if (wr && a < 8) begin
      if (q[a].size() < 4) q[a].push_back(wd);
      else m_ovf[a] = 1'b1;
    end
    if (rd && a < 8 && q[a].size() > 0) begin
      if (q[a].size() == 4) nfs[a] = 1'b1;
      void'(q[a].pop_front());
    end
    if (wr && a >= 8 && a < 16 && wd[8]) m_ovf[a-8] = 1'b0;
    for (int m = 0; m < 8; m++) ne[m] = (q[m].size() > 0);
    for (int u = 0; u < 4; u++) begin
      clr = (wr && a == 16 + u) ? wd[15:0] : 16'h0;
      m_new[u] = ne & ~clr[7:0];
      m_nf[u]  = nfs | (m_nf[u] & ~clr[15:8]);
      if (wr && a == 20 + u) m_en[u] = wd[15:0];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step("R9 idle", 1'b0, 1'b0, 0, 32'h0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 8; m++) m_ovf[m] = 1'b0;
    for (int u = 0; u < 4; u++) begin m_new[u] = '0; m_nf[u] = '0; m_en[u] = '0; end
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    check("R1 irq after reset", {28'b0, irq}, 32'h0);
    for (int a = 8; a < 24; a++) step("R1 reset regs", 1'b1, 1'b0, a, 0);

    // R9 enable programming and readback
    step("R9 en wr", 1'b0, 1'b1, 20, 32'h0000_00FF);
    step("R9 en wr", 1'b0, 1'b1, 21, 32'hFFFF_FF00);
    step("R9 en wr", 1'b0, 1'b1, 22, 32'h0000_0004);
    for (int a = 20; a < 24; a++) step("R9 en readback", 1'b1, 1'b0, a, 0);

    // R2 / R5 / R6 three messages through mailbox 0
    step("R2 post", 1'b0, 1'b1, 0, 32'hA000_0001);
    step("R2 post", 1'b0, 1'b1, 0, 32'hA000_0002);
    step("R2 post", 1'b0, 1'b1, 0, 32'hA000_0003);
    step("R5 status", 1'b1, 1'b0, 8, 0);
    step("R6 user status", 1'b1, 1'b0, 16, 0);
    step("R9 other mailbox", 1'b1, 1'b0, 9, 0);
    for (int i = 0; i < 3; i++) step("R2 fetch order", 1'b1, 1'b0, 0, 0);
    // R3 empty reads
    step("R3 empty read", 1'b1, 1'b0, 0, 0);
    step("R3 empty read", 1'b1, 1'b0, 0, 0);
    step("R3 count zero", 1'b1, 1'b0, 8, 0);
    step("R6 cleared by empty", 1'b1, 1'b0, 16, 0);

    // R4 fill mailbox 2 past its limit
    for (int i = 0; i < 5; i++) step("R4 fill", 1'b0, 1'b1, 2, 32'hB000_0000 + i);
    step("R4 R5 full and overflow", 1'b1, 1'b0, 10, 0);
    step("R7 pop from full", 1'b1, 1'b0, 2, 0);
    step("R7 nf set", 1'b1, 1'b0, 17, 0);
    step("R4 ovf clear", 1'b0, 1'b1, 10, 32'h0000_0100);
    step("R4 ovf cleared", 1'b1, 1'b0, 10, 0);
    // R6 clear while words remain
    step("R6 w1c", 1'b0, 1'b1, 18, 32'h0000_0004);
    step("R6 dropped", 1'b1, 1'b0, 18, 0);
    step("R6 back", 1'b1, 1'b0, 18, 0);
    // R7 sticky until cleared
    idle(3);
    step("R7 still set", 1'b1, 1'b0, 17, 0);
    step("R7 w1c", 1'b0, 1'b1, 17, 32'h0000_0400);
    step("R7 cleared", 1'b1, 1'b0, 17, 0);
    for (int i = 0; i < 3; i++) step("R2 drain", 1'b1, 1'b0, 2, 0);
    idle(2);

    // R9 mixed pseudo-random traffic on all mailboxes
    for (int i = 0; i < 3000; i++) begin
      int sel, a;
      sel = $urandom_range(0, 9);
      if (sel < 4)       step("R2 rnd post", 1'b0, 1'b1, $urandom_range(0, 7), $urandom);
      else if (sel < 7)  step("R2 rnd fetch", 1'b1, 1'b0, $urandom_range(0, 7), 0);
      else if (sel == 7) begin
        a = $urandom_range(8, 23);
        step("R9 rnd read", 1'b1, 1'b0, a, 0);
      end else if (sel == 8) begin
        a = $urandom_range(8, 23);
        step("R9 rnd reg write", 1'b0, 1'b1, a, $urandom);
      end else idle(1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule